// File: doc/BRIEF.md
# Packet DMA Channel Control Registers

This block is the register file sitting in front of a packet-driven disk DMA engine. Software reaches it through a plain memory-mapped port: a byte address, a 32-bit write word with four byte enables, a read strobe and a 32-bit read word. Each channel owns a 32-byte window. In it sit a 16-bit control register, an 8-bit event status register, a packet count, a 32-bit pointer to the next command packet, and two 16-bit FIFO thresholds, one for input and one for output. The stored values drive the engine directly.

A single byte outside the channel windows acts as a guard for the whole block. Unless it holds the key value 7, a request to start a packet has no effect. When the start request is accepted, the block emits a one-cycle start pulse to the engine. A control bit holds the engine in reset, and the engine reports packet-status, parity-error and unexpected-interrupt events back into the status register. Reading the status byte returns the collected events and clears them. Each channel raises an interrupt while any event is pending, unless that channel's interrupt is masked.

Top module: `pkt_dma_ctrl_regs`

## Requirements
- R1: Channel n occupies byte addresses 0x80+0x20*n to 0x9F+0x20*n, with NUM_CH = 2 by default. Inside a window the byte offsets are as follows. Word 0x00 holds control in bits 15:0 and status in bits 23:16 (offset 0x02). Offset 0x04 holds the packet count in bits 15:0. Offset 0x0C holds the next-packet pointer. Word 0x14 holds the input threshold in bits 15:0 and the output threshold in bits 31:16 (offset 0x16). The guard byte is at 0xC7, which is bits 31:24 of word 0xC4.
- R2: After reset the following values hold: control 0, status 0, pointer 0, guard 0, packet count 1, and both FIFO thresholds 0x100.
- R3: A write updates only the byte lanes whose enables are set. The count, pointer and threshold outputs always show the stored values.
- R4: A write of word 0 with lane 0 enabled and bit 7 set, while the guard holds 7, gives start_o high for exactly the one cycle after the write. Bit 7 always reads back as 0.
- R5: While the guard does not hold 7, the start bit is ignored. The guard changes only on a write to word 0xC4 with lane 3 enabled.
- R6: eng_rst_o follows control bit 5. Writing the bit as 1 holds the engine in reset from the next cycle, and writing it as 0 releases the engine.
- R7: Three engine events are collected in the status register: status bit 0 is a parity error, bit 4 is an unexpected interrupt, and bit 6 is a packet-status event. A read of word 0 with lane 2 enabled returns these bits and clears them. An event that arrives in the same cycle as that read stays set. Writes never change the status register.
- R8: irq_o of a channel is high whenever its status is nonzero and control bit 8 (interrupt mask, 1 = masked) is 0.
- R9: rdata_o carries the addressed word in the cycle after rd_en_i and is 0 otherwise. Unmapped addresses read as 0, and writes to them change nothing.
- R10: pio_mode_o shows control bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address, word aligned |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| be_i | input | 4 | Byte lane enables |
| rdata_o | output | 32 | Read data, one cycle after rd_en_i |
| evt_done_i | input | NUM_CH | Packet-status event per channel |
| evt_perr_i | input | NUM_CH | Parity error event per channel |
| evt_uirq_i | input | NUM_CH | Unexpected interrupt event per channel |
| start_o | output | NUM_CH | One-cycle start pulse per channel |
| eng_rst_o | output | NUM_CH | Engine reset per channel |
| irq_o | output | NUM_CH | Masked interrupt per channel |
| pio_mode_o | output | NUM_CH x 2 | Transfer mode field per channel |
| pkt_cnt_o | output | NUM_CH x 16 | Packet count per channel |
| next_ptr_o | output | NUM_CH x 32 | Next-packet pointer per channel |
| fifo_in_thr_o | output | NUM_CH x 16 | Input FIFO threshold per channel |
| fifo_out_thr_o | output | NUM_CH x 16 | Output FIFO threshold per channel |

## Verification
The hardest case to reach is an engine event that arrives in the very cycle a clearing status read is sampled. The stimulus lines up the event strobe and the read strobe in one call, so both land on the same edge, and then reads the status again to show the new event survived the clear. Guard handling is the other subtle area. The bench writes the key with lane 3 disabled, writes a wrong key, and issues back-to-back start writes, all against a reference model that is compared on every clock.

// File: rtl/pkt_regs_pkg.sv
package pkt_regs_pkg;

    localparam int CTL_MASK_BIT = 8;
    localparam int CTL_GO_BIT   = 7;
    localparam int CTL_RST_BIT  = 5;

    localparam int ST_PERR_BIT  = 0;
    localparam int ST_UIRQ_BIT  = 4;
    localparam int ST_PKT_BIT   = 6;

    localparam int W_CTRL = 0;
    localparam int W_CNT  = 1;
    localparam int W_PTR  = 3;
    localparam int W_FIFO = 5;

    localparam logic [15:0] CNT_RST  = 16'd1;
    localparam logic [15:0] THR_RST  = 16'h0100;
    localparam logic [7:0]  LOCK_KEY = 8'h07;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [7:0]  stat;
        logic [15:0] cnt;
        logic [31:0] ptr;
        logic [15:0] fin;
        logic [15:0] fout;
        logic        start;
    } chan_state_t;

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  be);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = be[i] ? new_v[8*i +: 8] : old_v[8*i +: 8];
        return r;
    endfunction

endpackage

// File: rtl/pkt_lock_reg.sv
module pkt_lock_reg #(
    parameter int LANE = 3
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        sel_i,
    input  logic        wr_en_i,
    input  logic [31:0] wdata_i,
    input  logic [3:0]  be_i,
    output logic        lock_ok_o,
    output logic [31:0] rdata_o
);
    import pkt_regs_pkg::*;

    logic [7:0] lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (sel_i && wr_en_i && be_i[LANE])
            lock_d = wdata_i[8*LANE +: 8];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lock_q <= '0;
        else         lock_q <= lock_d;
    end

    assign lock_ok_o = (lock_q == LOCK_KEY);

    always_comb begin
        rdata_o = '0;
        if (sel_i) rdata_o[8*LANE +: 8] = lock_q;
    end

    // R5
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(sel_i && wr_en_i) |=> $stable(lock_q));

endmodule

// File: rtl/pkt_chan_regs.sv
module pkt_chan_regs #(
    parameter int WORD_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sel_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic [31:0]       wdata_i,
    input  logic [3:0]        be_i,
    input  logic              lock_ok_i,
    input  logic              evt_done_i,
    input  logic              evt_perr_i,
    input  logic              evt_uirq_i,
    output logic [31:0]       rdata_o,
    output logic              start_o,
    output logic              eng_rst_o,
    output logic              irq_o,
    output logic [1:0]        pio_mode_o,
    output logic [15:0]       pkt_cnt_o,
    output logic [31:0]       next_ptr_o,
    output logic [15:0]       fifo_in_thr_o,
    output logic [15:0]       fifo_out_thr_o
);
    import pkt_regs_pkg::*;

    chan_state_t st_d, st_q;
    logic        wr_hit, rd_hit, go_req, clr_req;
    logic [7:0]  evt_bits;
    logic [31:0] tmp;

    assign wr_hit  = sel_i && wr_en_i;
    assign rd_hit  = sel_i && rd_en_i;
    assign go_req  = wr_hit && (int'(word_i) == W_CTRL) && be_i[0]
                     && wdata_i[CTL_GO_BIT] && lock_ok_i;
    assign clr_req = rd_hit && (int'(word_i) == W_CTRL) && be_i[2];

    always_comb begin
        evt_bits = '0;
        evt_bits[ST_PERR_BIT] = evt_perr_i;
        evt_bits[ST_UIRQ_BIT] = evt_uirq_i;
        evt_bits[ST_PKT_BIT]  = evt_done_i;
    end

    always_comb begin
        st_d       = st_q;
        tmp        = '0;
        st_d.start = go_req;
        st_d.stat  = (clr_req ? 8'h00 : st_q.stat) | evt_bits;
        if (wr_hit) begin
            case (int'(word_i))
                W_CTRL: begin
                    tmp = lane_merge({16'h0, st_q.ctrl}, wdata_i, {2'b00, be_i[1:0]});
                    st_d.ctrl = tmp[15:0];
                    st_d.ctrl[CTL_GO_BIT] = 1'b0;
                end
                W_CNT: begin
                    tmp = lane_merge({16'h0, st_q.cnt}, wdata_i, {2'b00, be_i[1:0]});
                    st_d.cnt = tmp[15:0];
                end
                W_PTR: st_d.ptr = lane_merge(st_q.ptr, wdata_i, be_i);
                W_FIFO: begin
                    tmp = lane_merge({st_q.fout, st_q.fin}, wdata_i, be_i);
                    st_d.fin  = tmp[15:0];
                    st_d.fout = tmp[31:16];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.cnt   <= CNT_RST;
            st_q.fin   <= THR_RST;
            st_q.fout  <= THR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (sel_i) begin
            case (int'(word_i))
                W_CTRL: rdata_o = {8'h00, st_q.stat, st_q.ctrl};
                W_CNT:  rdata_o = {16'h0, st_q.cnt};
                W_PTR:  rdata_o = st_q.ptr;
                W_FIFO: rdata_o = {st_q.fout, st_q.fin};
                default: rdata_o = '0;
            endcase
        end
    end

    assign start_o        = st_q.start;
    assign eng_rst_o      = st_q.ctrl[CTL_RST_BIT];
    assign irq_o          = (|st_q.stat) && !st_q.ctrl[CTL_MASK_BIT];
    assign pio_mode_o     = st_q.ctrl[1:0];
    assign pkt_cnt_o      = st_q.cnt;
    assign next_ptr_o     = st_q.ptr;
    assign fifo_in_thr_o  = st_q.fin;
    assign fifo_out_thr_o = st_q.fout;

    // R4
    go_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_o |-> $past(wr_hit && wdata_i[CTL_GO_BIT] && be_i[0]));

    // R5
    no_go_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_ok_i |=> !start_o);

    // R7
    perr_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_perr_i |=> st_q.stat[ST_PERR_BIT]);

    // R8
    irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.ctrl[CTL_MASK_BIT] |-> !irq_o);

endmodule

// File: rtl/pkt_dma_ctrl_regs.sv
module pkt_dma_ctrl_regs #(
    parameter int NUM_CH    = 2,
    parameter int ADDR_W    = 8,
    parameter int CH_BASE   = 'h80,
    parameter int CH_STRIDE = 32,
    parameter int LOCK_ADDR = 'hC7
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    wr_en_i,
    input  logic                    rd_en_i,
    input  logic [31:0]             wdata_i,
    input  logic [3:0]              be_i,
    output logic [31:0]             rdata_o,
    input  logic [NUM_CH-1:0]       evt_done_i,
    input  logic [NUM_CH-1:0]       evt_perr_i,
    input  logic [NUM_CH-1:0]       evt_uirq_i,
    output logic [NUM_CH-1:0]       start_o,
    output logic [NUM_CH-1:0]       eng_rst_o,
    output logic [NUM_CH-1:0]       irq_o,
    output logic [NUM_CH-1:0][1:0]  pio_mode_o,
    output logic [NUM_CH-1:0][15:0] pkt_cnt_o,
    output logic [NUM_CH-1:0][31:0] next_ptr_o,
    output logic [NUM_CH-1:0][15:0] fifo_in_thr_o,
    output logic [NUM_CH-1:0][15:0] fifo_out_thr_o
);
    localparam int OFF_W     = $clog2(CH_STRIDE);
    localparam int WORD_W    = OFF_W - 2;
    localparam int CH_TAG    = CH_BASE / CH_STRIDE;
    localparam int LOCK_WORD = LOCK_ADDR / 4;
    localparam int LOCK_LANE = LOCK_ADDR % 4;

    logic [NUM_CH-1:0]       ch_sel;
    logic [NUM_CH-1:0][31:0] ch_rdata;
    logic                    lock_sel, lock_ok;
    logic [31:0]             lock_rdata, rd_mux;
    logic [31:0]             rdata_d, rdata_q;

    assign lock_sel = (int'(addr_i[ADDR_W-1:2]) == LOCK_WORD);

    pkt_lock_reg #(.LANE(LOCK_LANE)) u_lock (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sel_i     (lock_sel),
        .wr_en_i   (wr_en_i),
        .wdata_i   (wdata_i),
        .be_i      (be_i),
        .lock_ok_o (lock_ok),
        .rdata_o   (lock_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign ch_sel[i] = (int'(addr_i[ADDR_W-1:OFF_W]) == CH_TAG + i);

        pkt_chan_regs #(.WORD_W(WORD_W)) u_chan (
            .clk_i          (clk_i),
            .rst_ni         (rst_ni),
            .sel_i          (ch_sel[i]),
            .wr_en_i        (wr_en_i),
            .rd_en_i        (rd_en_i),
            .word_i         (addr_i[OFF_W-1:2]),
            .wdata_i        (wdata_i),
            .be_i           (be_i),
            .lock_ok_i      (lock_ok),
            .evt_done_i     (evt_done_i[i]),
            .evt_perr_i     (evt_perr_i[i]),
            .evt_uirq_i     (evt_uirq_i[i]),
            .rdata_o        (ch_rdata[i]),
            .start_o        (start_o[i]),
            .eng_rst_o      (eng_rst_o[i]),
            .irq_o          (irq_o[i]),
            .pio_mode_o     (pio_mode_o[i]),
            .pkt_cnt_o      (pkt_cnt_o[i]),
            .next_ptr_o     (next_ptr_o[i]),
            .fifo_in_thr_o  (fifo_in_thr_o[i]),
            .fifo_out_thr_o (fifo_out_thr_o[i])
        );
    end

    always_comb begin
        rd_mux = lock_rdata;
        for (int i = 0; i < NUM_CH; i++)
            rd_mux = rd_mux | ch_rdata[i];
        rdata_d = rd_en_i ? rd_mux : 32'h0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;

    // R9
    rdata_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_en_i |=> (rdata_o == 32'h0));

endmodule

// File: tb/pkt_dma_ctrl_regs_test.sv
module pkt_dma_ctrl_regs_test;
    localparam int NCH = 2;

    logic clk = 0;
    logic rst_n = 0;
    always #2 clk = ~clk;

    logic [7:0]  addr = 0;
    logic        wr = 0, rd = 0;
    logic [31:0] wdata = 0;
    logic [3:0]  be = 0;
    logic [NCH-1:0] ev_done = 0, ev_perr = 0, ev_uirq = 0;
    logic [31:0] rdata;
    logic [NCH-1:0] start, erst, irq;
    logic [NCH-1:0][1:0]  pio;
    logic [NCH-1:0][15:0] cnt, fin, fout;
    logic [NCH-1:0][31:0] ptr;

    pkt_dma_ctrl_regs uut (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .rd_en_i(rd),
        .wdata_i(wdata), .be_i(be), .rdata_o(rdata),
        .evt_done_i(ev_done), .evt_perr_i(ev_perr), .evt_uirq_i(ev_uirq),
        .start_o(start), .eng_rst_o(erst), .irq_o(irq), .pio_mode_o(pio),
        .pkt_cnt_o(cnt), .next_ptr_o(ptr), .fifo_in_thr_o(fin), .fifo_out_thr_o(fout)
    );

    int checks = 0, errors = 0;
    bit done = 0;

    // behavioural reference state
    logic [15:0] m_ctrl [NCH];
    logic [7:0]  m_stat [NCH];
    logic [15:0] m_cnt  [NCH];
    logic [31:0] m_ptr  [NCH];
    logic [15:0] m_fin  [NCH];
    logic [15:0] m_fout [NCH];
    logic        m_start[NCH];
    logic [7:0]  m_lock;
    logic [31:0] m_rdata;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int word_of(input int ch, input logic [7:0] a);
        int base = 'h80 + 32 * ch;
        if (int'(a) >= base && int'(a) < base + 32) return (int'(a) - base) / 4;
        return -1;
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        for (int ch = 0; ch < NCH; ch++) begin
            case (word_of(ch, a))
                0: return {8'h00, m_stat[ch], m_ctrl[ch]};
                1: return {16'h0, m_cnt[ch]};
                3: return m_ptr[ch];
                5: return {m_fout[ch], m_fin[ch]};
                default: ;
            endcase
            if (word_of(ch, a) >= 0) return 32'h0;
        end
        if (a[7:2] == 6'h31) return {m_lock, 24'h0};
        return 32'h0;
    endfunction

    function automatic logic [7:0] mrg8(input logic [7:0] o, input logic [7:0] n, input logic e);
        return e ? n : o;
    endfunction

    task automatic model_step();
        logic [7:0] evb;
        m_rdata = rd ? m_read(addr) : 32'h0;
        for (int ch = 0; ch < NCH; ch++) begin
            int w = word_of(ch, addr);
            evb = {1'b0, ev_done[ch], 1'b0, ev_uirq[ch], 3'b000, ev_perr[ch]};
            m_start[ch] = wr && w == 0 && be[0] && wdata[7] && m_lock == 8'h07;
            if (rd && w == 0 && be[2]) m_stat[ch] = evb;
            else                      m_stat[ch] = m_stat[ch] | evb;
            if (wr) begin
                if (w == 0) begin
                    m_ctrl[ch] = {mrg8(m_ctrl[ch][15:8], wdata[15:8], be[1]),
                                  mrg8(m_ctrl[ch][7:0], wdata[7:0], be[0])};
                    m_ctrl[ch][7] = 1'b0;
                end
                if (w == 1) m_cnt[ch] = {mrg8(m_cnt[ch][15:8], wdata[15:8], be[1]),
                                         mrg8(m_cnt[ch][7:0], wdata[7:0], be[0])};
                if (w == 3) m_ptr[ch] = {mrg8(m_ptr[ch][31:24], wdata[31:24], be[3]),
                                         mrg8(m_ptr[ch][23:16], wdata[23:16], be[2]),
                                         mrg8(m_ptr[ch][15:8], wdata[15:8], be[1]),
                                         mrg8(m_ptr[ch][7:0], wdata[7:0], be[0])};
                if (w == 5) begin
                    m_fin[ch]  = {mrg8(m_fin[ch][15:8], wdata[15:8], be[1]),
                                  mrg8(m_fin[ch][7:0], wdata[7:0], be[0])};
                    m_fout[ch] = {mrg8(m_fout[ch][15:8], wdata[31:24], be[3]),
                                  mrg8(m_fout[ch][7:0], wdata[23:16], be[2])};
                end
            end
        end
        if (wr && addr[7:2] == 6'h31 && be[3]) m_lock = wdata[31:24];
    endtask

    task automatic compare(input string tag);
        for (int ch = 0; ch < NCH; ch++) begin
            chk(tag, "R4 start", 32'(start[ch]), 32'(m_start[ch]));
            chk(tag, "R6 eng_rst", 32'(erst[ch]), 32'(m_ctrl[ch][5]));
            chk(tag, "R8 irq", 32'(irq[ch]), 32'((|m_stat[ch]) && !m_ctrl[ch][8]));
            chk(tag, "R10 pio", 32'(pio[ch]), 32'(m_ctrl[ch][1:0]));
            chk(tag, "R3 count", 32'(cnt[ch]), 32'(m_cnt[ch]));
            chk(tag, "R3 pointer", ptr[ch], m_ptr[ch]);
            chk(tag, "R3 fifo_in", 32'(fin[ch]), 32'(m_fin[ch]));
            chk(tag, "R3 fifo_out", 32'(fout[ch]), 32'(m_fout[ch]));
        end
        chk(tag, "R9 rdata", rdata, m_rdata);
    endtask

    task automatic cyc(input logic w, input logic r, input logic [7:0] a,
                       input logic [31:0] d, input logic [3:0] b,
                       input logic [1:0] ed, input logic [1:0] ep, input logic [1:0] eu,
                       input string tag);
        wr = w; rd = r; addr = a; wdata = d; be = b;
        ev_done = ed; ev_perr = ep; ev_uirq = eu;
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wrt(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b,
                       input string tag);
        cyc(1, 0, a, d, b, 0, 0, 0, tag);
    endtask

    task automatic rdr(input logic [7:0] a, input string tag);
        cyc(0, 1, a, 0, 4'hF, 0, 0, 0, tag);
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    initial begin
        for (int ch = 0; ch < NCH; ch++) begin
            m_ctrl[ch] = 0; m_stat[ch] = 0; m_cnt[ch] = 1; m_ptr[ch] = 0;
            m_fin[ch] = 16'h100; m_fout[ch] = 16'h100; m_start[ch] = 0;
        end
        m_lock = 0; m_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare("R2 reset");
        // R2 / R1: read every register of both channels and the guard
        rdr(8'h80, "R2"); rdr(8'h84, "R2"); rdr(8'h8C, "R2"); rdr(8'h94, "R2");
        rdr(8'hA0, "R1"); rdr(8'hA4, "R1"); rdr(8'hAC, "R1"); rdr(8'hB4, "R1");
        rdr(8'hC4, "R2");
        // R3: byte-lane writes
        wrt(8'h84, 32'hFFFF_1234, 4'h3, "R3");
        wrt(8'h8C, 32'hDEAD_BEE8, 4'hF, "R3");
        wrt(8'hAC, 32'h1122_3344, 4'h3, "R3");
        wrt(8'h94, 32'h0200_0080, 4'hC, "R3");
        wrt(8'hB4, 32'h0040_0020, 4'h1, "R3");
        rdr(8'h84, "R3"); rdr(8'h8C, "R3"); rdr(8'hAC, "R3"); rdr(8'h94, "R1"); rdr(8'hB4, "R1");
        // R10: mode bits
        wrt(8'hA0, 32'h0000_0003, 4'h1, "R10");
        wrt(8'h80, 32'h0000_0002, 4'h3, "R10");
        // R5: start ignored while unlocked, with wrong key, and with lane 3 off
        wrt(8'h80, 32'h0000_0083, 4'h1, "R5");
        idle("R5");
        wrt(8'hC4, 32'h0500_0000, 4'h8, "R5");
        wrt(8'h80, 32'h0000_0083, 4'h1, "R5");
        wrt(8'hC4, 32'h0707_0707, 4'h7, "R5");
        wrt(8'h80, 32'h0000_0083, 4'h1, "R5");
        rdr(8'hC4, "R5");
        // R4: locked start, single pulse, back-to-back, reads 0
        wrt(8'hC4, 32'h0700_0000, 4'h8, "R4");
        wrt(8'h80, 32'h0000_0083, 4'h1, "R4");
        idle("R4");
        rdr(8'h80, "R4");
        wrt(8'hA0, 32'h0000_0083, 4'h1, "R4");
        wrt(8'hA0, 32'h0000_0083, 4'h1, "R4");
        idle("R4");
        wrt(8'h80, 32'h0000_0080, 4'h2, "R4");
        idle("R4");
        // R6: engine reset set then released
        wrt(8'h80, 32'h0000_0123, 4'h3, "R6");
        idle("R6");
        wrt(8'h80, 32'h0000_0003, 4'h3, "R6");
        idle("R6");
        // R7 / R8: events, masking, clear-on-read, same-cycle event
        cyc(0, 0, 0, 0, 0, 2'b00, 2'b01, 2'b00, "R7");
        cyc(0, 0, 0, 0, 0, 2'b00, 2'b00, 2'b10, "R8");
        wrt(8'hA0, 32'h0000_0103, 4'h3, "R8");
        cyc(0, 0, 0, 0, 0, 2'b11, 2'b00, 2'b00, "R7");
        wrt(8'h80, 32'h00FF_0003, 4'h4, "R7");
        cyc(0, 1, 8'h80, 0, 4'h3, 2'b00, 2'b00, 2'b00, "R7");
        cyc(0, 1, 8'h80, 0, 4'hF, 2'b00, 2'b01, 2'b00, "R7");
        rdr(8'h80, "R7");
        rdr(8'h80, "R7");
        rdr(8'hA0, "R8");
        wrt(8'hA0, 32'h0000_0003, 4'h3, "R8");
        cyc(0, 0, 0, 0, 0, 2'b10, 2'b10, 2'b10, "R8");
        rdr(8'hA0, "R7");
        // R9: unmapped space
        wrt(8'h40, 32'hFFFF_FFFF, 4'hF, "R9");
        wrt(8'h88, 32'hFFFF_FFFF, 4'hF, "R9");
        wrt(8'hC0, 32'hFFFF_FFFF, 4'hF, "R9");
        rdr(8'h40, "R9"); rdr(8'h88, "R9"); rdr(8'hC0, "R9"); rdr(8'hE0, "R9");
        cyc(1, 1, 8'h84, 32'h0000_5555, 4'h3, 0, 0, 0, "R9");
        rdr(8'h84, "R9");
        idle("R9"); idle("R9");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule